// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder

The block adds two 32-bit single-precision binary floating-point numbers over several clock cycles. A strobe/acknowledge handshake brings in each operand, first the augend and then the addend. A third handshake hands back the rounded sum. The machine handles one addition at a time. It moves through unpacking, special-value screening, alignment, mantissa add or subtract, normalisation, rounding and packing. To subtract, the caller inverts bit 31 of the second operand before sending it.

The datapath is built for small area. One stage shifts the operand with the smaller exponent right by one bit per cycle and ORs every lost bit into a sticky bit. Another stage shifts a result that lacks its leading one left by one bit per cycle, and stops at the smallest normal exponent. This is how denormal operands and denormal results are handled. Latency therefore depends on the data: it ranges from four cycles for a special value to a few hundred cycles when the exponents are far apart. Rounding is to nearest, with ties going to the even mantissa.

Top module: `fp32_seq_adder`

## Requirements
- R1: `a_ack` is high only while the block waits for the first operand, and `b_ack` only while it waits for the second, so the two are never high together. An operand is taken on a rising edge where its strobe and acknowledge are both high. While the block waits for `a`, `b_ack` stays low.
- R2: When the result is ready, `z_stb` goes high. `z_stb` and `z_data` then hold unchanged until a rising edge with `z_ack` high. In the next cycle `z_stb` is low and `a_ack` is high.
- R3: For finite nonzero normal operands, `z_data` is the exact sum rounded to nearest, ties to even. This includes an exact tie and operands whose exponents differ by more than the mantissa width.
- R4: Operands with exponent field 0 (denormals) are added correctly. A result below the smallest normal magnitude comes out as a denormal, with exponent field 0. A denormal sum that rounds or carries up to the smallest normal comes out with exponent field 1.
- R5: Adding a finite nonzero value to its exact negation gives +0 (32'h00000000) in both operand orders.
- R6: -0 plus -0 gives 32'h80000000. +0 plus -0 gives 32'h00000000. A zero plus a nonzero x gives x bit for bit.
- R7: A NaN operand (exponent field all ones, fraction nonzero) gives the quiet NaN 32'h7FC00000. So does +infinity plus -infinity. Every NaN the block puts out is exactly 32'h7FC00000.
- R8: An infinity (exponent field all ones, fraction zero) plus any finite value gives that infinity.
- R9: A sum whose rounded exponent exceeds the largest finite exponent gives infinity with the sign of the sum (32'h7F800000 or 32'hFF800000).
- R10: While `rst_n` is low, and after it is released, `z_stb` is 0, `a_ack` is 1 and `b_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_data | input | 32 | First operand |
| a_stb | input | 1 | First operand is valid |
| a_ack | output | 1 | Block is ready for the first operand |
| b_data | input | 32 | Second operand |
| b_stb | input | 1 | Second operand is valid |
| b_ack | output | 1 | Block is ready for the second operand |
| z_data | output | 32 | Rounded sum |
| z_stb | output | 1 | Sum is valid |
| z_ack | input | 1 | Receiver takes the sum |

## Verification
The hardest conditions to reach from the ports are the rounding boundaries at the ends of the two iterative loops. One is a carry from rounding that turns a denormal into the smallest normal. Another is a mantissa of all ones that rounds up into the next binade, or past the largest finite exponent. A third is a near-cancellation that forces many left shifts before the loop stops at the minimum exponent. Directed operand pairs target each of these edges exactly. Random pairs are then drawn with forced equal exponents, forced zero exponent fields and near-negated operands, so that these paths are hit many times rather than by chance. Each result is compared with a behavioural model that aligns in one wide shift. The consumer's acknowledge is delayed so that the hold rule is also exercised.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int EXT_W  = MANT_W + 3;
  localparam int SUM_W  = EXT_W + 1;
  localparam int EI_W   = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN   = 1 - BIAS;
  localparam int EINF   = (1 << EXP_W) - 1;

  typedef logic signed [EI_W-1:0] exp_t;

  typedef struct packed {
    logic              sign;
    exp_t              exp;
    logic [MANT_W-1:0] mant;
    logic              is_zero;
    logic              is_inf;
    logic              is_nan;
  } fp_unpk_t;

  typedef enum logic [3:0] {
    S_GET_A, S_GET_B, S_SPECIAL, S_ALIGN, S_ADD,
    S_NORM1, S_NORM2, S_FINISH, S_PUT
  } st_t;

  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fp_unpk_t          u
);
  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] fr;

  assign ef = word[WORD_W-2:FRAC_W];
  assign fr = word[FRAC_W-1:0];

  always_comb begin
    u.sign    = word[WORD_W-1];
    u.is_nan  = (&ef) && (|fr);
    u.is_inf  = (&ef) && !(|fr);
    u.is_zero = (ef == '0) && (fr == '0);
    if (ef == '0) begin
      u.exp  = exp_t'(EMIN);
      u.mant = {1'b0, fr};
    end else begin
      u.exp  = exp_t'({{(EI_W-EXP_W){1'b0}}, ef}) - exp_t'(BIAS);
      u.mant = {1'b1, fr};
    end
  end
endmodule

// File: rtl/fpadd_round_pack.sv
module fpadd_round_pack
  import fpadd_pkg::*;
(
  input  logic              sign,
  input  exp_t              e,
  input  logic [MANT_W-1:0] m,
  input  logic              g,
  input  logic              r,
  input  logic              s,
  output logic [WORD_W-1:0] word
);
  logic              up;
  logic              cy;
  logic [MANT_W-1:0] mr;
  exp_t              er;
  exp_t              eb;

  always_comb begin
    up        = g & (r | s | m[0]);
    {cy, mr}  = {1'b0, m} + {{MANT_W{1'b0}}, up};
    er        = e;
    if (cy) begin
      mr = {1'b1, {FRAC_W{1'b0}}};
      er = e + exp_t'(1);
    end
    eb = er + exp_t'(BIAS);
    if (eb >= exp_t'(EINF))
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if ((er == exp_t'(EMIN)) && !mr[MANT_W-1])
      word = {sign, {EXP_W{1'b0}}, mr[FRAC_W-1:0]};
    else
      word = {sign, eb[EXP_W-1:0], mr[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fp32_seq_adder.sv
module fp32_seq_adder
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] a_data,
  input  logic              a_stb,
  output logic              a_ack,
  input  logic [WORD_W-1:0] b_data,
  input  logic              b_stb,
  output logic              b_ack,
  output logic [WORD_W-1:0] z_data,
  output logic              z_stb,
  input  logic              z_ack
);
  st_t               state, state_n;
  logic [WORD_W-1:0] a_q, a_n, b_q, b_n, z_q, z_n;
  logic [EXT_W-1:0]  ma, ma_n, mb, mb_n;
  exp_t              ea, ea_n, eb, eb_n, ze, ze_n;
  logic              sa, sa_n, sb, sb_n, zs, zs_n;
  logic [SUM_W-1:0]  sum, sum_n;
  logic [MANT_W-1:0] zm, zm_n;
  logic              gq, gq_n, rq, rq_n, sq, sq_n;
  fp_unpk_t          ua, ub;
  logic [WORD_W-1:0] rp_word;

  fpadd_unpack u_unp_a (.word(a_q), .u(ua));
  fpadd_unpack u_unp_b (.word(b_q), .u(ub));

  fpadd_round_pack u_rnd (
    .sign(zs), .e(ze), .m(zm), .g(gq), .r(rq), .s(sq), .word(rp_word)
  );

  always_comb begin
    state_n = state;
    a_n = a_q;  b_n = b_q;  z_n = z_q;
    ma_n = ma;  mb_n = mb;  ea_n = ea;  eb_n = eb;
    sa_n = sa;  sb_n = sb;  zs_n = zs;  ze_n = ze;
    sum_n = sum; zm_n = zm;
    gq_n = gq;  rq_n = rq;  sq_n = sq;
    case (state)
      S_GET_A: if (a_stb) begin
        a_n = a_data;
        state_n = S_GET_B;
      end
      S_GET_B: if (b_stb) begin
        b_n = b_data;
        state_n = S_SPECIAL;
      end
      S_SPECIAL: begin
        ma_n = {ua.mant, 3'b000};
        mb_n = {ub.mant, 3'b000};
        ea_n = ua.exp;  eb_n = ub.exp;
        sa_n = ua.sign; sb_n = ub.sign;
        state_n = S_PUT;
        if (ua.is_nan || ub.is_nan ||
            (ua.is_inf && ub.is_inf && (ua.sign != ub.sign)))
          z_n = QNAN;
        else if (ua.is_inf)
          z_n = a_q;
        else if (ub.is_inf)
          z_n = b_q;
        else if (ua.is_zero && ub.is_zero)
          z_n = {ua.sign & ub.sign, {(WORD_W-1){1'b0}}};
        else if (ua.is_zero)
          z_n = b_q;
        else if (ub.is_zero)
          z_n = a_q;
        else
          state_n = S_ALIGN;
      end
      S_ALIGN: begin
        if (ea > eb) begin
          eb_n = eb + exp_t'(1);
          mb_n = {1'b0, mb[EXT_W-1:2], mb[1] | mb[0]};
        end else if (eb > ea) begin
          ea_n = ea + exp_t'(1);
          ma_n = {1'b0, ma[EXT_W-1:2], ma[1] | ma[0]};
        end else begin
          state_n = S_ADD;
        end
      end
      S_ADD: begin
        ze_n = ea;
        if (sa == sb) begin
          sum_n = {1'b0, ma} + {1'b0, mb};
          zs_n  = sa;
        end else if (ma >= mb) begin
          sum_n = {1'b0, ma} - {1'b0, mb};
          zs_n  = (ma == mb) ? 1'b0 : sa;
        end else begin
          sum_n = {1'b0, mb} - {1'b0, ma};
          zs_n  = sb;
        end
        state_n = S_NORM1;
      end
      S_NORM1: begin
        if (sum[SUM_W-1]) begin
          zm_n = sum[SUM_W-1:4];
          gq_n = sum[3];
          rq_n = sum[2];
          sq_n = sum[1] | sum[0];
          ze_n = ze + exp_t'(1);
        end else begin
          zm_n = sum[SUM_W-2:3];
          gq_n = sum[2];
          rq_n = sum[1];
          sq_n = sum[0];
        end
        state_n = S_NORM2;
      end
      S_NORM2: begin
        if (!zm[MANT_W-1] && (ze > exp_t'(EMIN))) begin
          zm_n = {zm[MANT_W-2:0], gq};
          gq_n = rq;
          rq_n = 1'b0;
          ze_n = ze - exp_t'(1);
        end else begin
          state_n = S_FINISH;
        end
      end
      S_FINISH: begin
        z_n = rp_word;
        state_n = S_PUT;
      end
      S_PUT: if (z_ack) state_n = S_GET_A;
      default: state_n = S_GET_A;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_GET_A;
    else        state <= state_n;
  end

  always_ff @(posedge clk) begin
    a_q <= a_n;  b_q <= b_n;  z_q <= z_n;
    ma <= ma_n;  mb <= mb_n;  ea <= ea_n;  eb <= eb_n;
    sa <= sa_n;  sb <= sb_n;  zs <= zs_n;  ze <= ze_n;
    sum <= sum_n; zm <= zm_n;
    gq <= gq_n;  rq <= rq_n;  sq <= sq_n;
  end

  assign a_ack  = (state == S_GET_A);
  assign b_ack  = (state == S_GET_B);
  assign z_stb  = (state == S_PUT);
  assign z_data = z_q;

  // R1
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ack && b_ack));
  // R1
  a_then_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_stb && a_ack) |=> (b_ack && !a_ack));
  // R2
  z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_stb && !z_ack) |=> (z_stb && $stable(z_data)));
  // R2
  z_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_stb && z_ack) |=> (a_ack && !z_stb));
  // R7
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_stb && (&z_data[WORD_W-2:FRAC_W]) && (|z_data[FRAC_W-1:0]))
      |-> (z_data == QNAN));
  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (a_ack && !b_ack && !z_stb));
endmodule

// File: tb/sim_fp32_seq_adder.sv
`timescale 1ns/1ps
module sim_fp32_seq_adder;
  localparam real CLK_HALF = 4.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_data = '0, b_data = '0;
  logic        a_stb = 1'b0, b_stb = 1'b0, z_ack = 1'b0;
  logic        a_ack, b_ack, z_stb;
  logic [31:0] z_data;
  int          n_tests = 0, n_fail = 0;

  always #(CLK_HALF) clk = ~clk;

  fp32_seq_adder u0 (
    .clk(clk), .rst_n(rst_n),
    .a_data(a_data), .a_stb(a_stb), .a_ack(a_ack),
    .b_data(b_data), .b_stb(b_stb), .b_ack(b_ack),
    .z_data(z_data), .z_stb(z_stb), .z_ack(z_ack)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural model: one wide alignment shift, leading-one search, then rounding
  function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b);
    logic        sa, sb, sz, up;
    int          ea, eb, e, d;
    logic [63:0] ma, mb, m, lost, tmp;
    logic [31:0] rem;
    logic [24:0] keep;
    if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0))
      return 32'h7FC00000;
    if (a[30:23] == 8'hFF && b[30:23] == 8'hFF)
      return (a[31] != b[31]) ? 32'h7FC00000 : a;
    if (a[30:23] == 8'hFF) return a;
    if (b[30:23] == 8'hFF) return b;
    if (a[30:0] == 0 && b[30:0] == 0) return {a[31] & b[31], 31'd0};
    if (a[30:0] == 0) return b;
    if (b[30:0] == 0) return a;
    sa = a[31]; sb = b[31];
    ea = (a[30:23] == 0) ? -126 : int'(a[30:23]) - 127;
    eb = (b[30:23] == 0) ? -126 : int'(b[30:23]) - 127;
    ma = {40'd0, (a[30:23] != 0), a[22:0]} << 32;
    mb = {40'd0, (b[30:23] != 0), b[22:0]} << 32;
    if (ea < eb) begin
      tmp = ma; ma = mb; mb = tmp;
      d = ea; ea = eb; eb = d;
      up = sa; sa = sb; sb = up;
    end
    d = ea - eb;
    if (d > 60) mb = (mb != 0) ? 64'd1 : 64'd0;
    else if (d > 0) begin
      lost = mb & ((64'd1 << d) - 64'd1);
      mb = (mb >> d) | {63'd0, (lost != 0)};
    end
    if (sa == sb) begin m = ma + mb; sz = sa; end
    else if (ma >= mb) begin m = ma - mb; sz = (ma == mb) ? 1'b0 : sa; end
    else begin m = mb - ma; sz = sb; end
    e = ea;
    if (m[56]) begin m = (m >> 1) | {63'd0, m[0]}; e++; end
    while (!m[55] && e > -126) begin m = m << 1; e--; end
    rem  = m[31:0];
    keep = {1'b0, m[55:32]};
    up   = (rem > 32'h8000_0000) || (rem == 32'h8000_0000 && keep[0]);
    keep = keep + {24'd0, up};
    if (keep[24]) begin keep = keep >> 1; e++; end
    if (e > 127) return {sz, 8'hFF, 23'd0};
    if (!keep[23]) return {sz, 8'd0, keep[22:0]};
    return {sz, 8'(e + 127), keep[22:0]};
  endfunction

  task automatic run_one(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp, input int hold);
    logic [31:0] held;
    @(negedge clk);
    check({tag, " R1 b_ack low while waiting for a"}, {31'd0, b_ack}, 32'd0);
    a_data = a; a_stb = 1'b1;
    while (!a_ack) @(negedge clk);
    @(negedge clk);
    a_stb = 1'b0; a_data = 32'hDEADBEEF;
    b_data = b; b_stb = 1'b1;
    while (!b_ack) @(negedge clk);
    @(negedge clk);
    b_stb = 1'b0; b_data = 32'hDEADBEEF;
    while (!z_stb) @(negedge clk);
    held = z_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check({tag, " R2 z held"}, {z_stb, z_data}, {1'b1, held});
    end
    check(tag, z_data, exp);
    z_ack = 1'b1;
    @(negedge clk);
    z_ack = 1'b0;
    check({tag, " R2 release"}, {30'd0, z_stb, a_ack}, 32'd1);
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    repeat (2) @(negedge clk);
    check("R10 reset z_stb", {31'd0, z_stb}, 32'd0);
    check("R10 reset a_ack", {31'd0, a_ack}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", {29'd0, z_stb, a_ack, b_ack}, 32'd2);

    run_one("R3 1+1",        32'h3F800000, 32'h3F800000, 32'h40000000, 0);
    run_one("R3 tie even",   32'h3F800000, 32'h33800000, 32'h3F800000, 2);
    run_one("R3 tie odd",    32'h3F800001, 32'h33800000, 32'h3F800002, 0);
    run_one("R3 far apart",  32'h3F800000, 32'h00000001, 32'h3F800000, 1);
    run_one("R3 sub",        32'h40400000, 32'hBF800000, 32'h40000000, 0);
    run_one("R5 x+-x",       32'h40490FDB, 32'hC0490FDB, 32'h00000000, 0);
    run_one("R5 -x+x",       32'hC0490FDB, 32'h40490FDB, 32'h00000000, 3);
    run_one("R5 -den+den",   32'h80000005, 32'h00000005, 32'h00000000, 0);
    run_one("R4 den+den",    32'h00000001, 32'h00000001, 32'h00000002, 0);
    run_one("R4 min-ulp",    32'h00800000, 32'h80000001, 32'h007FFFFF, 0);
    run_one("R4 to normal",  32'h007FFFFF, 32'h00000001, 32'h00800000, 0);
    run_one("R6 -0+-0",      32'h80000000, 32'h80000000, 32'h80000000, 0);
    run_one("R6 +0+-0",      32'h00000000, 32'h80000000, 32'h00000000, 0);
    run_one("R6 0+x",        32'h00000000, 32'hC0000000, 32'hC0000000, 0);
    run_one("R6 x+-0",       32'h00000003, 32'h80000000, 32'h00000003, 0);
    run_one("R7 nan",        32'h7F800001, 32'h3F800000, 32'h7FC00000, 0);
    run_one("R7 inf-inf",    32'h7F800000, 32'hFF800000, 32'h7FC00000, 1);
    run_one("R8 inf+1",      32'h7F800000, 32'h3F800000, 32'h7F800000, 0);
    run_one("R8 1+-inf",     32'h3F800000, 32'hFF800000, 32'hFF800000, 0);
    run_one("R9 max+max",    32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 0);
    run_one("R9 -max+-max",  32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 0);
    run_one("R9 round over", 32'h7F7FFFFF, 32'h73000000, 32'h7F800000, 0);

    for (int i = 0; i < 240; i++) begin
      ra = $urandom; rb = $urandom;
      case (i % 4)
        1: rb[30:23] = ra[30:23];
        2: begin ra[30:23] = 8'd0; rb[30:23] = (i % 8 == 2) ? 8'd0 : 8'd1; end
        3: rb = (ra ^ 32'h80000000) ^ ($urandom & 32'h7);
        default: ;
      endcase
      if (i % 4 == 2) run_one("R4 random", ra, rb, ref_add(ra, rb), i % 3);
      else            run_one("R3 random", ra, rb, ref_add(ra, rb), i % 3);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule